// File: doc/BRIEF.md
# Asynchronous Write Sequencer with Wait Stall

This block carries out one asynchronous write to an external device. Once a start request is accepted it captures the address and data. A cycle counter then runs, and it advances once per divided clock period. The active-low chip-select and write-enable strobes come from comparing that counter with programmed on and off times. The data bus is driven until the counter reaches the programmed cycle time. At that point every strobe is released and a single-cycle completion pulse is issued.

A device that cannot keep up can hold off the write with its ready/wait line, if monitoring is enabled. The line passes through a two-stage synchronizer, and the block looks at it when the counter equals the access time. An active wait level freezes the counter. While it is frozen the strobes keep their levels and the data stays on the bus. When the line goes inactive the counter resumes. An optional extra delay, counted in divided clock periods, can be placed in front of the resume.

A timing set that breaks the ordering rules is reported on a flag, and a start request is refused while that flag is set.

Top module: `awr_wait_seq`

## Requirements
- R1: After reset the block is idle: cs_n and we_n are 1, data_oe and done are 0.
- R2: One count lasts div_sel+1 clock cycles. After a start accepted at clock edge E0, the count equals k from edge E0+k(div_sel+1). cs_n is 0 while cs_on <= count < cs_off, and we_n is 0 while we_on <= count < we_off. Without a stall, done is 1 in the cycle after edge E0+cyc_time(div_sel+1)+1.
- R3: data_oe is 1 from acceptance until the count reaches cyc_time, and also during any stall. While data_oe is 1, data_out and addr_out carry the values captured at acceptance.
- R4: With mon_en=0 the wait input is ignored and the timing matches R2.
- R5: With mon_en=1, a wait level that is active when the count equals acc_time freezes the count. During the freeze the strobes hold their levels and the data stays driven.
- R6: If the wait input goes inactive between edges Er and Er+1 and wait_dly=0, the count leaves the freeze at edge Er+3, which reflects the two-stage synchronizer. From there the rest of the access runs as in R2 from the point where the count reached acc_time.
- R7: With wait_dly=x>0 the release from the freeze comes x(div_sel+1) cycles later than in R6. If wait becomes active again during that delay, the block returns to the frozen state at once.
- R8: wait_hi=1 makes a high wait_in the active (not-ready) level. wait_hi=0 makes a low level active.
- R9: done is a one-cycle pulse. In the cycle where done is 1, the strobes are released and data_oe is 0. A start request during an access is ignored.
- R10: cfg_err is 1 when any of these holds: cs_on > cs_off, we_on > we_off, cs_off > cyc_time, we_off > cyc_time, acc_time >= cyc_time. While cfg_err is 1 a start request is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Write request, accepted when idle |
| addr_in | input | AW | Write address |
| data_in | input | DW | Write data |
| div_sel | input | DIVW | Clock divide setting, count period = div_sel+1 cycles |
| cyc_time | input | TW | Count at which the access ends |
| acc_time | input | TW | Count at which the wait line is examined |
| cs_on | input | TW | Chip-select assert count |
| cs_off | input | TW | Chip-select release count |
| we_on | input | TW | Write-enable assert count |
| we_off | input | TW | Write-enable release count |
| wait_dly | input | XDW | Extra divided cycles before unfreezing |
| mon_en | input | 1 | Enable wait monitoring for writes |
| wait_hi | input | 1 | Wait polarity, 1 = high means not ready |
| wait_in | input | 1 | Asynchronous wait line from the device |
| cs_n | output | 1 | Chip select, active low |
| we_n | output | 1 | Write enable, active low |
| addr_out | output | AW | Captured address |
| data_out | output | DW | Captured write data |
| data_oe | output | 1 | Data bus output enable |
| done | output | 1 | One-cycle completion pulse |
| cfg_err | output | 1 | Timing set violates ordering rules |

## Verification
The bench builds the block with its default parameters: 5-bit timing fields, 16-bit address and data, a 2-bit divider and a 2-bit extra delay. These widths are small enough that every combination of divider, extra delay, wait polarity, monitor enable and stalled or free wait line can be exercised with one fixed timing set. For each combination the bench works out the expected latency and strobe widths arithmetically. Separate runs cover a start request issued mid-access and timing sets that break the ordering rules.

// File: rtl/awr_pkg.sv
package awr_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_HOLD = 2'd2,
      ST_XDLY = 2'd3
   } awr_state_e;

   localparam int unsigned NUM_STROBES = 2;
   localparam int unsigned STB_CS      = 0;
   localparam int unsigned STB_WE      = 1;
endpackage

// File: rtl/awr_tick_gen.sv
module awr_tick_gen #(
   parameter int unsigned DIVW = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic            run,
   input  logic [DIVW-1:0] div_sel,
   output logic            tick
);
   localparam logic [DIVW-1:0] PH_ONE = 1;

   generate
      if (DIVW < 1) begin : g_bad_divw
         $error("awr_tick_gen: DIVW must be at least 1");
      end
   endgenerate

   logic [DIVW-1:0] phase;

   assign tick = run && (phase == div_sel);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         phase <= '0;
      else if (clr)
         phase <= '0;
      else if (run)
         phase <= tick ? '0 : phase + PH_ONE;
   end
endmodule

// File: rtl/awr_wait_sync.sv
module awr_wait_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wait_in,
   input  logic active_high,
   output logic wait_act
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("awr_wait_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         chain <= '0;
      else
         chain <= {chain[STAGES-2:0], wait_in};
   end

   assign wait_act = active_high ? chain[STAGES-1] : ~chain[STAGES-1];
endmodule

// File: rtl/awr_strobe_gen.sv
module awr_strobe_gen #(
   parameter int unsigned TW = 5,
   parameter int unsigned NS = 2
) (
   input  logic                 active,
   input  logic [TW-1:0]        cnt,
   input  logic [TW-1:0]        cyc_time,
   input  logic [NS-1:0][TW-1:0] on_t,
   input  logic [NS-1:0][TW-1:0] off_t,
   output logic [NS-1:0]        strobe_n,
   output logic                 data_oe,
   output logic                 order_bad
);
   generate
      if (NS < 1) begin : g_bad_ns
         $error("awr_strobe_gen: NS must be at least 1");
      end
   endgenerate

   logic [NS-1:0] bad_vec;

   for (genvar i = 0; i < NS; i++) begin : g_stb
      assign strobe_n[i] = ~(active && (cnt >= on_t[i]) && (cnt < off_t[i]));
      assign bad_vec[i]  = (on_t[i] > off_t[i]) || (off_t[i] > cyc_time);
   end

   assign data_oe   = active && (cnt < cyc_time);
   assign order_bad = |bad_vec;
endmodule

// File: rtl/awr_wait_seq.sv
module awr_wait_seq
   import awr_pkg::*;
#(
   parameter int unsigned AW          = 16,
   parameter int unsigned DW          = 16,
   parameter int unsigned TW          = 5,
   parameter int unsigned DIVW        = 2,
   parameter int unsigned XDW         = 2,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [AW-1:0]   addr_in,
   input  logic [DW-1:0]   data_in,
   input  logic [DIVW-1:0] div_sel,
   input  logic [TW-1:0]   cyc_time,
   input  logic [TW-1:0]   acc_time,
   input  logic [TW-1:0]   cs_on,
   input  logic [TW-1:0]   cs_off,
   input  logic [TW-1:0]   we_on,
   input  logic [TW-1:0]   we_off,
   input  logic [XDW-1:0]  wait_dly,
   input  logic            mon_en,
   input  logic            wait_hi,
   input  logic            wait_in,
   output logic            cs_n,
   output logic            we_n,
   output logic [AW-1:0]   addr_out,
   output logic [DW-1:0]   data_out,
   output logic            data_oe,
   output logic            done,
   output logic            cfg_err
);
   localparam logic [TW-1:0]  CNT_ONE = 1;
   localparam logic [XDW-1:0] DLY_ONE = 1;

   generate
      if (TW < 2 || AW < 1 || DW < 1 || XDW < 1) begin : g_bad_widths
         $error("awr_wait_seq: unsupported width parameters");
      end
   endgenerate

   awr_state_e     state;
   logic [TW-1:0]  cnt;
   logic [XDW-1:0] dcnt;
   logic           wact;
   logic           tick;
   logic           order_bad;
   logic           accept;
   logic           at_end;
   logic           freeze_now;
   logic           tick_run;
   logic           tick_clr;
   logic [NUM_STROBES-1:0]         stb_n;
   logic [NUM_STROBES-1:0][TW-1:0] on_vec;
   logic [NUM_STROBES-1:0][TW-1:0] off_vec;

   assign on_vec[STB_CS]  = cs_on;
   assign on_vec[STB_WE]  = we_on;
   assign off_vec[STB_CS] = cs_off;
   assign off_vec[STB_WE] = we_off;

   assign cfg_err    = order_bad || (acc_time >= cyc_time);
   assign accept     = (state == ST_IDLE) && start && !cfg_err;
   assign at_end     = (cnt == cyc_time);
   assign freeze_now = mon_en && wact && (cnt == acc_time) && !at_end;
   assign tick_run   = ((state == ST_RUN) && !at_end && !freeze_now) ||
                       (state == ST_XDLY);
   assign tick_clr   = accept || ((state == ST_HOLD) && !wact);

   awr_tick_gen #(.DIVW(DIVW)) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (tick_clr),
      .run     (tick_run),
      .div_sel (div_sel),
      .tick    (tick)
   );

   awr_wait_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk         (clk),
      .rst_n       (rst_n),
      .wait_in     (wait_in),
      .active_high (wait_hi),
      .wait_act    (wact)
   );

   awr_strobe_gen #(.TW(TW), .NS(NUM_STROBES)) u_stb (
      .active    (state != ST_IDLE),
      .cnt       (cnt),
      .cyc_time  (cyc_time),
      .on_t      (on_vec),
      .off_t     (off_vec),
      .strobe_n  (stb_n),
      .data_oe   (data_oe),
      .order_bad (order_bad)
   );

   assign cs_n = stb_n[STB_CS];
   assign we_n = stb_n[STB_WE];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cnt      <= '0;
         dcnt     <= '0;
         done     <= 1'b0;
         addr_out <= '0;
         data_out <= '0;
      end else begin
         done <= (state == ST_RUN) && at_end;
         case (state)
            ST_IDLE: begin
               if (accept) begin
                  state    <= ST_RUN;
                  cnt      <= '0;
                  addr_out <= addr_in;
                  data_out <= data_in;
               end
            end
            ST_RUN: begin
               if (at_end)
                  state <= ST_IDLE;
               else if (freeze_now)
                  state <= ST_HOLD;
               else if (tick)
                  cnt <= cnt + CNT_ONE;
            end
            ST_HOLD: begin
               if (!wact) begin
                  if (wait_dly == '0) begin
                     state <= ST_RUN;
                  end else begin
                     state <= ST_XDLY;
                     dcnt  <= wait_dly;
                  end
               end
            end
            ST_XDLY: begin
               if (wact)
                  state <= ST_HOLD;
               else if (tick) begin
                  if (dcnt == DLY_ONE)
                     state <= ST_RUN;
                  else
                     dcnt <= dcnt - DLY_ONE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/awr_wait_seq_chk.sv
module awr_wait_seq_chk
   import awr_pkg::*;
#(
   parameter int unsigned TW = 5,
   parameter int unsigned DW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input awr_state_e    state,
   input logic [TW-1:0] cnt,
   input logic          wact,
   input logic          mon_en,
   input logic          cs_n,
   input logic          we_n,
   input logic          data_oe,
   input logic [DW-1:0] data_out,
   input logic          done,
   input logic          cfg_err
);
   // R3: captured write data never changes while the bus is driven
   a_r3_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (data_oe && $past(data_oe)) |-> $stable(data_out));

   // R5: count is frozen while stalled
   a_r5_hold_count: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HOLD) |=> (cnt == $past(cnt)));

   // R5: strobes keep their levels and data stays driven during a stall
   a_r5_hold_outputs: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HOLD && $past(state) == ST_HOLD) |->
         ($stable(cs_n) && $stable(we_n) && data_oe));

   // R4: no stall entered when monitoring is off
   a_r4_no_stall_unmonitored: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RUN && !mon_en) |=> (state != ST_HOLD));

   // R7: reassertion during the extra delay returns to the stall at once
   a_r7_reassert_stalls: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_XDLY && wact) |=> (state == ST_HOLD));

   // R9: completion is a single-cycle pulse
   a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9: completion releases strobes and bus
   a_r9_done_release: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (cs_n && we_n && !data_oe));

   // R10: a bad timing set keeps the block idle
   a_r10_err_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && cfg_err) |=> (state == ST_IDLE));
endmodule

bind awr_wait_seq awr_wait_seq_chk #(.TW(TW), .DW(DW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .state    (state),
   .cnt      (cnt),
   .wact     (wact),
   .mon_en   (mon_en),
   .cs_n     (cs_n),
   .we_n     (we_n),
   .data_oe  (data_oe),
   .data_out (data_out),
   .done     (done),
   .cfg_err  (cfg_err)
);

// File: tb/awr_wait_seq_test.sv
`timescale 1ns/1ps
module awr_wait_seq_test;
   localparam int C = 12, A = 6, CSON = 1, CSOFF = 11, WEON = 3, WEOFF = 9;

   logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
   logic [15:0] addr_in = '0, data_in = '0;
   logic [1:0]  div_sel = '0, wait_dly = '0;
   logic [4:0]  cyc_time = 5'(C), acc_time = 5'(A);
   logic [4:0]  cs_on = 5'(CSON), cs_off = 5'(CSOFF), we_on = 5'(WEON), we_off = 5'(WEOFF);
   logic        mon_en = 1'b0, wait_hi = 1'b1, wait_in = 1'b0;
   logic        cs_n, we_n, data_oe, done, cfg_err;
   logic [15:0] addr_out, data_out;

   int n_chk = 0, n_bad = 0;

   awr_wait_seq uut (
      .clk(clk), .rst_n(rst_n), .start(start), .addr_in(addr_in), .data_in(data_in),
      .div_sel(div_sel), .cyc_time(cyc_time), .acc_time(acc_time),
      .cs_on(cs_on), .cs_off(cs_off), .we_on(we_on), .we_off(we_off),
      .wait_dly(wait_dly), .mon_en(mon_en), .wait_hi(wait_hi), .wait_in(wait_in),
      .cs_n(cs_n), .we_n(we_n), .addr_out(addr_out), .data_out(data_out),
      .data_oe(data_oe), .done(done), .cfg_err(cfg_err)
   );

   always #2.5 clk = ~clk;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic run_access(input int d, input int x, input int mon, input int hold,
                             input int pol, input bit poke);
      int R, base, mexp, F, done_m, cs_c, we_c, oe_c, csx, wex;
      bit data_ok, frozen;
      logic [15:0] dv, av;
      string lat_req;
      dv = 16'(16'h1234 + d*4096 + x*256 + mon*32 + hold*4 + pol);
      av = ~dv;
      @(negedge clk);
      div_sel = 2'(d); wait_dly = 2'(x); mon_en = 1'(mon); wait_hi = 1'(pol);
      wait_in = (hold != 0) ? 1'(pol) : ~1'(pol);
      data_in = dv; addr_in = av;
      repeat (4) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      R = A*(d+1) + 5;
      done_m = 0; cs_c = 0; we_c = 0; oe_c = 0; data_ok = 1'b1;
      for (int m = 1; m <= 400; m++) begin
         if (done) begin
            done_m = m;
            check(cs_n && we_n && !data_oe, "R9 release at done", int'({cs_n, we_n, data_oe}), 6);
            break;
         end
         if (!cs_n) cs_c++;
         if (!we_n) we_c++;
         if (data_oe) begin
            oe_c++;
            if (data_out !== dv || addr_out !== av) data_ok = 1'b0;
         end
         if (m == R) wait_in = ~1'(pol);
         if (poke && m == 3) begin start = 1'b1; data_in = ~dv; end
         if (poke && m == 4) start = 1'b0;
         @(negedge clk);
      end
      frozen = (mon != 0) && (hold != 0);
      base = C*(d+1) + 2;
      mexp = frozen ? (R + 4 + (x + C - A)*(d+1)) : base;
      F = mexp - base;
      csx = (CSOFF-CSON)*(d+1) + ((A >= CSON && A < CSOFF) ? F : 0);
      wex = (WEOFF-WEON)*(d+1) + ((A >= WEON && A < WEOFF) ? F : 0);
      if (frozen) lat_req = (x != 0) ? "R7 delayed release latency" : "R6 release latency";
      else if (hold != 0) lat_req = "R4 wait ignored latency";
      else lat_req = "R2 free-running latency";
      check(done_m == mexp, lat_req, done_m, mexp);
      if (mon != 0)
         check((done_m > base) == (hold != 0), "R8 polarity detection", done_m, mexp);
      check(cs_c == csx, frozen ? "R5 cs width with stall" : "R2 cs width", cs_c, csx);
      check(we_c == wex, frozen ? "R5 we width with stall" : "R2 we width", we_c, wex);
      check(oe_c == C*(d+1) + F, "R3 data enable width", oe_c, C*(d+1) + F);
      check(data_ok, frozen ? "R5 data held during stall" : "R3 data and address", 0, 1);
      @(negedge clk);
      check(!done && cs_n, "R9 done single pulse", int'(done), 0);
      if (poke) begin
         int lows = 0;
         for (int k = 0; k < 12; k++) begin
            if (!cs_n || done || data_oe) lows++;
            @(negedge clk);
         end
         check(lows == 0, "R9 start during access ignored", lows, 0);
      end
      wait_in = ~1'(pol);
   endtask

   initial begin
      #(200000.0 * 5.0);
      n_bad++;
      $display("FAIL R9 watchdog expired actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(cs_n && we_n && !data_oe && !done, "R1 reset state",
            int'({cs_n, we_n, data_oe, done}), 12);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(cs_n && we_n && !data_oe && !done, "R1 idle after reset",
            int'({cs_n, we_n, data_oe, done}), 12);
      check(!cfg_err, "R10 legal timing set", int'(cfg_err), 0);

      for (int pol = 0; pol < 2; pol++)
         for (int d = 0; d < 4; d++)
            for (int x = 0; x < 4; x++)
               for (int mon = 0; mon < 2; mon++)
                  for (int hold = 0; hold < 2; hold++)
                     run_access(d, x, mon, hold, pol, 1'b0);

      run_access(1, 0, 1, 0, 1, 1'b1);
      run_access(2, 1, 1, 1, 0, 1'b1);

      // R10: illegal timing sets block start
      begin
         int act;
         for (int v = 0; v < 3; v++) begin
            @(negedge clk);
            cs_off = 5'(CSOFF); acc_time = 5'(A); we_on = 5'(WEON);
            if (v == 0) cs_off = 5'(C + 1);
            if (v == 1) acc_time = 5'(C);
            if (v == 2) we_on = 5'(WEOFF + 1);
            @(negedge clk);
            check(cfg_err, "R10 flag raised", int'(cfg_err), 1);
            start = 1'b1;
            act = 0;
            for (int k = 0; k < 20; k++) begin
               @(negedge clk);
               start = 1'b0;
               if (!cs_n || !we_n || data_oe || done) act++;
            end
            check(act == 0, "R10 start refused", act, 0);
         end
         @(negedge clk);
         cs_off = 5'(CSOFF); acc_time = 5'(A); we_on = 5'(WEON);
         @(negedge clk);
         check(!cfg_err, "R10 flag cleared", int'(cfg_err), 0);
      end

      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule